// File: doc/BRIEF.md
# Lane-Partitioned Wide Operand ALU

This execution unit works on one 1024-bit wide register. Each instruction names two slices of that register. A slice starts at any 4-bit boundary and has a power-of-two width. The unit splits both slices into equal vector lanes and applies one operation to every lane. Carries and shifted bits never cross a lane boundary. The result overwrites the first slice, which is the destination. A caller can, for example, add sixteen 16-bit values in a single step, or shift every byte of a 64-bit slice by its own amount.

The caller presents a 32-bit instruction word and the current register contents, and pulses `in_valid`. On the next cycle the unit returns the updated register, a zero flag and a carry flag, and raises `out_done` for one cycle. The sequencer has two states. `ST_IDLE` waits for work. `ST_DONE` presents a result. In both states the transition *accept* (`in_valid` high) leads to `ST_DONE`, and the transition *drain* (`in_valid` low) leads to `ST_IDLE`.

Top module: `wlane_alu`

## Requirements
- R1: Instruction fields are: opcode in bits 31:22, width code in bits 21:19, lane code in bits 18:16, destination offset in bits 15:8 and source offset in bits 7:0. A size code n in 0..6 means 4·2^n bits, and code 7 means the full 1024 bits. The lane size is that of the lane code, limited to the operation width.
- R2: Operand A starts at bit destination offset × 4 and operand B at bit source offset × 4. Bit positions wrap modulo 1024. The result replaces exactly the destination window, also when it wraps, and every other register bit is copied unchanged.
- R3: Opcode 0 (add) adds A and B lane by lane, modulo the lane size, and no carry passes from one lane into the next.
- R4: Opcode 1 (subtract) computes A minus B in each lane, modulo the lane size.
- R5: Opcodes 2, 3 and 4 give A AND B, A OR B and A XOR B. Opcode 5 gives NOT B.
- R6: Opcode 6 shifts each lane of A left and opcode 7 shifts it right, both filling with zeros. The shift amount is that lane of B modulo the lane size.
- R7: Opcode 8 shifts each lane of A right and fills with the lane's top (sign) bit.
- R8: Opcode 9 rotates each lane of A left and opcode 10 rotates it right, using the same shift amount.
- R9: `flag_zero` is 1 when the result inside the operation width is all zero. For add, `flag_carry` is 1 when any lane carries out. For subtract, it is 1 when any lane borrows (A < B unsigned). For every other opcode it is 0.
- R10: Opcodes 11 and above leave the register unchanged, clear both flags, and still produce `out_done`.
- R11: `out_done` is high exactly in the cycle after each cycle in which `in_valid` is high. The outputs hold their values when no instruction is accepted. After reset, `out_done`, `wreg_out` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and register are presented this cycle |
| instr | input | 32 | Instruction word |
| wreg_in | input | 1024 | Current wide register contents |
| out_done | output | 1 | One-cycle strobe: result is valid |
| wreg_out | output | 1024 | Updated wide register |
| flag_zero | output | 1 | Result inside the operation width is zero |
| flag_carry | output | 1 | Any lane carried out (add) or borrowed (subtract) |

## Verification
The properties assume that `in_valid` is always a known level and that reset is applied before the first instruction. They place no limit on the instruction word, so reserved opcodes are legal stimulus. The stimulus pulses `in_valid` on falling edges and holds `wreg_in` steady through the capturing edge. It sends both isolated and back-to-back instructions, and it picks offsets that push windows across bit 1023 so that the wrap paths are covered.

// File: rtl/wlane_pkg.sv
package wlane_pkg;

    typedef enum logic [9:0] {
        OP_ADD = 10'd0,
        OP_SUB = 10'd1,
        OP_AND = 10'd2,
        OP_OR  = 10'd3,
        OP_XOR = 10'd4,
        OP_NOT = 10'd5,
        OP_SHL = 10'd6,
        OP_SHR = 10'd7,
        OP_SRA = 10'd8,
        OP_ROL = 10'd9,
        OP_ROR = 10'd10
    } wl_op_e;

    typedef enum logic [2:0] {
        SM_SHL,
        SM_SHR,
        SM_SRA,
        SM_ROL,
        SM_ROR
    } wl_shmode_e;

    typedef enum logic {
        ST_IDLE,
        ST_DONE
    } wl_state_e;

    // size code -> bit count: 4 << code, top code selects the whole register
    function automatic int unsigned code_bits(input logic [2:0] code, input int unsigned full);
        return (code == 3'd7) ? full : (32'd4 << code);
    endfunction

endpackage

// File: rtl/wlane_rot.sv
module wlane_rot #(
    parameter int W    = 1024,
    parameter bit LEFT = 1'b0,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    x,
    input  logic [SH_W-1:0] sh,
    output logic [W-1:0]    y
);
    logic [2*W-1:0] dbl;
    assign dbl = {x, x};

    generate
        if (LEFT) begin : g_left
            logic [SH_W:0] start;
            assign start = (SH_W+1)'(W) - {1'b0, sh};
            assign y = dbl[start +: W];
        end else begin : g_right
            assign y = dbl[{1'b0, sh} +: W];
        end
    endgenerate
endmodule

// File: rtl/wlane_addsub.sv
module wlane_addsub #(
    parameter int W   = 1024,
    parameter int NIB = 4,
    localparam int SH_W = $clog2(W),
    localparam int NIBS = W / NIB
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          sub,
    input  logic [SH_W:0] lane_bits,
    input  logic [SH_W:0] width_bits,
    output logic [W-1:0]  y,
    output logic          flag
);
    always_comb begin
        logic          c;
        logic [NIB:0]  t;
        logic [NIB-1:0] bn;
        int            lmask;
        y     = '0;
        flag  = 1'b0;
        c     = 1'b0;
        lmask = int'(lane_bits) - 1;
        for (int n = 0; n < NIBS; n++) begin
            if (((n * NIB) & lmask) == 0) c = sub;
            bn = sub ? ~b[n*NIB +: NIB] : b[n*NIB +: NIB];
            t  = {1'b0, a[n*NIB +: NIB]} + {1'b0, bn} + (NIB+1)'(c);
            y[n*NIB +: NIB] = t[NIB-1:0];
            c = t[NIB];
            if ((((n + 1) * NIB) & lmask) == 0 && (n + 1) * NIB <= int'(width_bits))
                flag = flag | (c ^ sub);
        end
    end
endmodule

// File: rtl/wlane_shift.sv
module wlane_shift
    import wlane_pkg::*;
#(
    parameter int W = 1024,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  wl_shmode_e    mode,
    input  logic [SH_W:0] lane_bits,
    output logic [W-1:0]  y
);
    always_comb begin
        logic [W-1:0] cur;
        logic [W-1:0] nxt;
        logic         en;
        int           lmask, p, base, d;
        cur   = a;
        lmask = int'(lane_bits) - 1;
        for (int k = 0; k < SH_W; k++) begin
            d   = 1 << k;
            nxt = cur;
            for (int i = 0; i < W; i++) begin
                p    = i & lmask;
                base = i - p;
                en   = 1'b0;
                if (d < int'(lane_bits)) en = b[base + k];
                if (en) begin
                    unique case (mode)
                        SM_SHL: begin
                            if (p >= d) nxt[i] = cur[i - d];
                            else        nxt[i] = 1'b0;
                        end
                        SM_SHR: begin
                            if (p + d <= lmask) nxt[i] = cur[i + d];
                            else                nxt[i] = 1'b0;
                        end
                        SM_SRA: begin
                            if (p + d <= lmask) nxt[i] = cur[i + d];
                            else                nxt[i] = cur[base + lmask];
                        end
                        SM_ROL: nxt[i] = cur[base + ((p - d) & lmask)];
                        SM_ROR: nxt[i] = cur[base + ((p + d) & lmask)];
                        default: nxt[i] = cur[i];
                    endcase
                end
            end
            cur = nxt;
        end
        y = cur;
    end
endmodule

// File: rtl/wlane_alu.sv
module wlane_alu
    import wlane_pkg::*;
#(
    parameter int REG_W   = 1024,
    parameter int NIB     = 4,
    parameter int OFF_W   = 8,
    parameter int INSTR_W = 32,
    localparam int SH_W    = $clog2(REG_W),
    localparam int NIB_LOG = $clog2(NIB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [REG_W-1:0]   wreg_in,
    output logic               out_done,
    output logic [REG_W-1:0]   wreg_out,
    output logic               flag_zero,
    output logic               flag_carry
);
    wl_state_e state, state_nxt;

    logic [9:0]       op;
    logic [2:0]       wcode, vcode;
    logic [OFF_W-1:0] doff, soff;
    logic [SH_W-1:0]  dsh, ssh;
    logic [SH_W:0]    wbits, lraw, lbits;
    logic [REG_W-1:0] opa, opb, wmask, res, res_m, ins, ins_mask, new_reg;
    logic [REG_W-1:0] as_y, sh_y;
    logic             as_flag, op_ok, is_sub, z_nxt, c_nxt;
    wl_shmode_e       sh_mode;

    assign op    = instr[31:22];
    assign wcode = instr[21:19];
    assign vcode = instr[18:16];
    assign doff  = instr[15:8];
    assign soff  = instr[7:0];
    assign dsh   = SH_W'({doff, {NIB_LOG{1'b0}}});
    assign ssh   = SH_W'({soff, {NIB_LOG{1'b0}}});

    assign wbits = (SH_W+1)'(code_bits(wcode, REG_W));
    assign lraw  = (SH_W+1)'(code_bits(vcode, REG_W));
    assign lbits = (lraw > wbits) ? wbits : lraw;
    assign wmask = {REG_W{1'b1}} >> (REG_W - int'(wbits));

    wlane_rot #(.W(REG_W), .LEFT(1'b0)) u_get_a (.x(wreg_in), .sh(dsh), .y(opa));
    wlane_rot #(.W(REG_W), .LEFT(1'b0)) u_get_b (.x(wreg_in), .sh(ssh), .y(opb));

    assign is_sub = (op == OP_SUB);

    wlane_addsub #(.W(REG_W), .NIB(NIB)) u_addsub (
        .a(opa), .b(opb), .sub(is_sub), .lane_bits(lbits),
        .width_bits(wbits), .y(as_y), .flag(as_flag)
    );

    wlane_shift #(.W(REG_W)) u_shift (
        .a(opa), .b(opb), .mode(sh_mode), .lane_bits(lbits), .y(sh_y)
    );

    always_comb begin
        op_ok   = 1'b1;
        res     = '0;
        sh_mode = SM_SHL;
        c_nxt   = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin res = as_y; c_nxt = as_flag; end
            OP_AND: res = opa & opb;
            OP_OR:  res = opa | opb;
            OP_XOR: res = opa ^ opb;
            OP_NOT: res = ~opb;
            OP_SHL: begin sh_mode = SM_SHL; res = sh_y; end
            OP_SHR: begin sh_mode = SM_SHR; res = sh_y; end
            OP_SRA: begin sh_mode = SM_SRA; res = sh_y; end
            OP_ROL: begin sh_mode = SM_ROL; res = sh_y; end
            OP_ROR: begin sh_mode = SM_ROR; res = sh_y; end
            default: op_ok = 1'b0;
        endcase
    end

    assign res_m = res & wmask;

    wlane_rot #(.W(REG_W), .LEFT(1'b1)) u_put_res  (.x(res_m), .sh(dsh), .y(ins));
    wlane_rot #(.W(REG_W), .LEFT(1'b1)) u_put_mask (.x(wmask), .sh(dsh), .y(ins_mask));

    assign new_reg = op_ok ? ((wreg_in & ~ins_mask) | ins) : wreg_in;
    assign z_nxt   = op_ok && (res_m == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions: accept -> ST_DONE, drain -> ST_IDLE
    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_nxt = in_valid ? ST_DONE : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_done = (state == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wreg_out   <= '0;
            flag_zero  <= 1'b0;
            flag_carry <= 1'b0;
        end else if (in_valid) begin
            wreg_out   <= new_reg;
            flag_zero  <= z_nxt;
            flag_carry <= c_nxt;
        end
    end
endmodule

// File: rtl/wlane_alu_chk.sv
module wlane_alu_chk #(
    parameter int REG_W   = 1024,
    parameter int INSTR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [REG_W-1:0]   wreg_in,
    input logic               out_done,
    input logic [REG_W-1:0]   wreg_out,
    input logic               flag_zero,
    input logic               flag_carry
);
    // R11
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);

    // R11
    done_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_done);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(wreg_out) && $stable(flag_zero) && $stable(flag_carry)));

    // R9
    carry_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:22] > 10'd1) |=> !flag_carry);

    // R10
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:22] > 10'd10) |=> (wreg_out == $past(wreg_in) && !flag_zero));
endmodule

bind wlane_alu wlane_alu_chk #(.REG_W(REG_W), .INSTR_W(INSTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .wreg_in(wreg_in), .out_done(out_done), .wreg_out(wreg_out),
    .flag_zero(flag_zero), .flag_carry(flag_carry)
);

// File: tb/wlane_alu_bench.sv
module wlane_alu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [RW-1:0] wreg_in = '0;
    logic          out_done;
    logic [RW-1:0] wreg_out;
    logic          flag_zero, flag_carry;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    logic [RW-1:0] q_reg[$];
    bit            q_z[$];
    bit            q_c[$];
    string         q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wlane_alu u_wlane_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .wreg_in(wreg_in), .out_done(out_done), .wreg_out(wreg_out),
        .flag_zero(flag_zero), .flag_carry(flag_carry)
    );

    function automatic int sz(input int code);
        return (code == 7) ? RW : (4 << code);
    endfunction

    function automatic logic [RW-1:0] rnd_reg();
        logic [RW-1:0] r;
        for (int i = 0; i < RW/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    // reference model, lane by lane on aligned copies
    task automatic model(input logic [RW-1:0] r, input int op, input int wc, input int vc,
                         input int d, input int s,
                         output logic [RW-1:0] exp_r, output bit z, output bit c);
        logic [RW-1:0] a, b, res, lm, la, lb, lr;
        logic [RW:0]   t;
        int w, l, sa;
        w = sz(wc);
        l = sz(vc);
        if (l > w) l = w;
        for (int i = 0; i < RW; i++) begin
            a[i] = r[(d*4 + i) % RW];
            b[i] = r[(s*4 + i) % RW];
        end
        c = 0;
        exp_r = r;
        if (op > 10) begin
            z = 0;
            return;
        end
        lm = (l == RW) ? {RW{1'b1}} : ((RW'(1) << l) - RW'(1));
        res = '0;
        for (int j = 0; j < w / l; j++) begin
            la = (a >> (j*l)) & lm;
            lb = (b >> (j*l)) & lm;
            sa = int'(lb % RW'(l));
            case (op)
                0: begin t = {1'b0, la} + {1'b0, lb}; lr = t[RW-1:0] & lm; if (t[l]) c = 1; end
                1: begin lr = (la - lb) & lm; if (la < lb) c = 1; end
                2: lr = la & lb;
                3: lr = la | lb;
                4: lr = la ^ lb;
                5: lr = ~lb & lm;
                6: lr = (la << sa) & lm;
                7: lr = la >> sa;
                8: begin
                    lr = la >> sa;
                    if (la[l-1]) lr = lr | (lm & ~(lm >> sa));
                end
                9: lr = ((la << sa) | (la >> (l - sa))) & lm;
                default: lr = ((la >> sa) | (la << (l - sa))) & lm;
            endcase
            res = res | (lr << (j*l));
        end
        z = (res == '0);
        for (int i = 0; i < w; i++) exp_r[(d*4 + i) % RW] = res[i];
    endtask

    // driver: presents one instruction at a falling edge, leaves in_valid high
    task automatic issue(input logic [RW-1:0] r, input int op, input int wc, input int vc,
                         input int d, input int s, input string tag);
        logic [RW-1:0] e;
        bit z, c;
        model(r, op, wc, vc, d, s, e, z, c);
        @(negedge clk);
        wreg_in  = r;
        instr    = {10'(op), 3'(wc), 3'(vc), 8'(d), 8'(s)};
        in_valid = 1'b1;
        q_reg.push_back(e);
        q_z.push_back(z);
        q_c.push_back(c);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input logic [RW-1:0] r, input int op, input int wc, input int vc,
                       input int d, input int s, input string tag);
        issue(r, op, wc, vc, d, s, tag);
        idle();
        idle();
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_done && !ended) begin
            total++;
            if (q_reg.size() == 0) begin
                bad++;
                $display("FAIL R11: done with nothing pending, actual done=1 expected done=0");
            end else begin
                logic [RW-1:0] er;
                bit ez, ec;
                string tg;
                er = q_reg.pop_front();
                ez = q_z.pop_front();
                ec = q_c.pop_front();
                tg = q_tag.pop_front();
                if (wreg_out !== er || flag_zero !== ez || flag_carry !== ec) begin
                    bad++;
                    $display("FAIL %s: actual z=%0b c=%0b reg=%h expected z=%0b c=%0b reg=%h",
                             tg, flag_zero, flag_carry, wreg_out, ez, ec, er);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [RW-1:0] r;
        repeat (3) @(negedge clk);
        // R11 reset state
        total++;
        if (out_done !== 1'b0 || wreg_out !== '0 || flag_zero !== 1'b0 || flag_carry !== 1'b0) begin
            bad++;
            $display("FAIL R11: reset actual done=%0b z=%0b c=%0b expected all zero",
                     out_done, flag_zero, flag_carry);
        end
        rst_n = 1'b1;
        idle();

        // R3 carry isolation: sixteen 16-bit lanes of FFFF + 1
        r = rnd_reg();
        r[255:0] = {256{1'b1}};
        for (int j = 0; j < 16; j++) r[256 + j*16 +: 16] = 16'h0001;
        run(r, 0, 6, 2, 0, 64, "R3");
        // R3 lane code larger than width is capped
        run(rnd_reg(), 0, 2, 7, 3, 10, "R3");
        run(rnd_reg(), 0, 5, 0, 17, 90, "R3");
        // R2 / R1 wrapping windows
        run(rnd_reg(), 0, 4, 4, 250, 5, "R2");
        run(rnd_reg(), 3, 6, 3, 200, 240, "R2");
        run(rnd_reg(), 2, 7, 7, 13, 77, "R1");
        // R4 subtract, including equal operands
        run(rnd_reg(), 1, 5, 1, 8, 40, "R4");
        run(rnd_reg(), 1, 6, 3, 21, 21, "R4");
        // R5 logic
        run(rnd_reg(), 2, 6, 6, 0, 32, "R5");
        run(rnd_reg(), 3, 5, 2, 4, 100, "R5");
        run(rnd_reg(), 4, 7, 5, 11, 3, "R5");
        run(rnd_reg(), 5, 4, 4, 30, 60, "R5");
        // R6 logical shifts
        run(rnd_reg(), 6, 6, 3, 0, 64, "R6");
        run(rnd_reg(), 7, 6, 1, 5, 70, "R6");
        run(rnd_reg(), 6, 7, 7, 0, 9, "R6");
        // R7 arithmetic shift with negative lanes
        r = rnd_reg();
        for (int j = 0; j < 8; j++) r[j*32 + 31] = 1'b1;
        run(r, 8, 6, 3, 0, 64, "R7");
        run(rnd_reg(), 8, 5, 0, 2, 50, "R7");
        // R8 rotates
        run(rnd_reg(), 9, 6, 2, 0, 80, "R8");
        run(rnd_reg(), 10, 5, 4, 240, 7, "R8");
        // R10 reserved opcodes
        run(rnd_reg(), 11, 6, 2, 0, 64, "R10");
        run(rnd_reg(), 1023, 3, 1, 9, 19, "R10");
        // R11 back-to-back
        issue(rnd_reg(), 0, 6, 2, 0, 64, "R11");
        issue(rnd_reg(), 7, 5, 3, 40, 8, "R11");
        issue(rnd_reg(), 1, 4, 4, 100, 150, "R11");
        idle();
        idle();
        // R9 flags across random mixes
        for (int k = 0; k < 60; k++)
            run(rnd_reg(), $urandom % 12, $urandom % 8, $urandom % 8,
                $urandom % 256, $urandom % 256, "R9");
        repeat (3) idle();
        total++;
        if (q_reg.size() != 0) begin
            bad++;
            $display("FAIL R11: pending results actual=%0d expected=0", q_reg.size());
        end
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule